// File: doc/BRIEF.md
# Prefix-Extended Immediate NOT Unit

This block is one execution slice of a core that issues 16-bit instruction words, one word per cycle. Each cycle it either accepts one word or sees an empty slot. It handles two kinds of word. An extension prefix carries a 13-bit field, and the unit remembers up to two of them. A register-immediate NOT builds a signed immediate, inverts every bit of it and writes the 32-bit result into one of sixteen registers. The immediate is 6, 19 or 32 bits wide, depending on how many prefixes are pending when the NOT arrives.

The prefix tracker is a three-state machine:

- `PFX_NONE`: nothing is pending.
- `PFX_ONE`: one field is held.
- `PFX_TWO`: two fields are held.

Its transitions are named as follows:

- `take_first`: a prefix word moves the machine from NONE to ONE.
- `take_second`: a prefix word moves the machine from ONE to TWO.
- `slide`: a prefix word in TWO drops the oldest field and keeps the newest two.
- `consume`: any valid non-prefix word returns the machine to NONE.
- `hold`: an empty slot leaves state and fields as they are.

A delay-slot input forces the NOT to use the plain 6-bit form, whatever is pending. A combinational read port exposes any register so its contents can be inspected.

Top module: `imm_not_unit`

## Requirements
- R1: Words are acted on only while `insn_valid` is 1. A word with bits 15:10 = 011111 is a NOT: bits 9:4 hold the 6-bit immediate and bits 3:0 name the destination register. A word with bits 15:13 = 110 is a prefix whose 13-bit field is bits 12:0. Any other valid word is a foreign opcode.
- R2: With no prefix pending, the destination receives the bitwise inverse of the 6-bit immediate sign-extended to 32 bits. For example, immediate 0x1f yields 0xffffffe0.
- R3: With one prefix pending, the prefix field forms bits 18:6 and the NOT field forms bits 5:0. This 19-bit value is sign-extended from bit 18 and inverted. For example, prefix 0x7ff with immediate 0x3f yields 0xfffe0000.
- R4: With two prefixes pending, the older field forms bits 31:19, the newer field forms bits 18:6 and the NOT field forms bits 5:0. The 32-bit value is inverted.
- R5: A third consecutive prefix discards the oldest held field, so the two most recent fields are used.
- R6: A NOT presented with `in_delay_slot` = 1 uses the 6-bit form even when prefixes are pending, and it clears them.
- R7: Any valid word that is not a prefix clears the pending prefixes. A foreign opcode changes no register and no flag.
- R8: After a NOT, `flag_n` equals bit 31 of the result, `flag_z` is 1 exactly when the result is zero, and `flag_v` is 0. `flag_c` never changes from its reset value of 0.
- R9: The result and flags appear at the outputs right after the single clock edge that accepts the NOT.
- R10: A cycle with `insn_valid` = 0 changes no register, no flag and no pending prefix.
- R11: An active-low reset clears all registers, all flags and the pending prefixes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word present this cycle |
| insn_word | input | 16 | Instruction word |
| in_delay_slot | input | 1 | Word sits in a branch delay slot |
| rd_addr | input | 4 | Register read-port address |
| rd_data | output | 32 | Contents of the addressed register |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The NOT's write and the clearing of the prefix state fall in the same cycle. Each NOT or foreign word both consumes the pending fields and, for a NOT, writes a result built from them. The bench provokes these collisions directly: NOTs in the delay slot with one or two fields pending, foreign words squeezed between prefixes and a NOT, and a long mixed stream. Each case is judged by the next NOT's result, which reveals whether stale fields leaked through. A behavioural model with a prefix queue is compared on every cycle against the flags and the last written register.

// File: rtl/inm_pkg.sv
`timescale 1ns/1ps
package inm_pkg;
    typedef enum logic [1:0] {
        PFX_NONE = 2'd0,
        PFX_ONE  = 2'd1,
        PFX_TWO  = 2'd2,
        PFX_RSVD = 2'd3
    } pfx_state_e;

    localparam logic [5:0] OPC_NOT = 6'b011111;
    localparam logic [2:0] OPC_PFX = 3'b110;
endpackage

// File: rtl/inm_prefix_fsm.sv
`timescale 1ns/1ps
module inm_prefix_fsm
    import inm_pkg::*;
#(
    parameter int FIELD_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid,
    input  logic               is_pfx,
    input  logic [FIELD_W-1:0] field,
    output pfx_state_e         state,
    output logic [FIELD_W-1:0] hi_field,
    output logic [FIELD_W-1:0] lo_field
);
    pfx_state_e         state_nx;
    logic [FIELD_W-1:0] hi_nx;
    logic [FIELD_W-1:0] lo_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= PFX_NONE;
            hi_field <= '0;
            lo_field <= '0;
        end else begin
            state    <= state_nx;
            hi_field <= hi_nx;
            lo_field <= lo_nx;
        end
    end

    always_comb begin
        state_nx = state;
        hi_nx    = hi_field;
        lo_nx    = lo_field;
        if (valid) begin
            if (is_pfx) begin
                unique case (state)
                    PFX_NONE: begin            // take_first
                        state_nx = PFX_ONE;
                        lo_nx    = field;
                    end
                    PFX_ONE: begin             // take_second
                        state_nx = PFX_TWO;
                        hi_nx    = lo_field;
                        lo_nx    = field;
                    end
                    PFX_TWO: begin             // slide
                        state_nx = PFX_TWO;
                        hi_nx    = lo_field;
                        lo_nx    = field;
                    end
                    default: begin
                        state_nx = PFX_ONE;
                        lo_nx    = field;
                    end
                endcase
            end else begin                     // consume
                state_nx = PFX_NONE;
                hi_nx    = '0;
                lo_nx    = '0;
            end
        end
    end

    // R5
    slide_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && is_pfx && state == PFX_TWO) |=> (hi_field == $past(lo_field) && state == PFX_TWO));

    // R7
    consume_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !is_pfx) |=> (state == PFX_NONE));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid) |=> ($stable(state) && $stable(lo_field) && $stable(hi_field)));
endmodule

// File: rtl/inm_imm_build.sv
`timescale 1ns/1ps
module inm_imm_build
    import inm_pkg::*;
#(
    parameter int FIELD_W = 13,
    parameter int IMM_W   = 6,
    parameter int DATA_W  = 32
) (
    input  pfx_state_e         state,
    input  logic [FIELD_W-1:0] hi_field,
    input  logic [FIELD_W-1:0] lo_field,
    input  logic [IMM_W-1:0]   imm_short,
    input  logic               delay_slot,
    output logic [DATA_W-1:0]  imm_full
);
    localparam int MID_W  = FIELD_W + IMM_W;
    localparam int LONG_W = 2 * FIELD_W + IMM_W;

    logic [DATA_W-1:0] form_short;
    logic [DATA_W-1:0] form_mid;
    logic [DATA_W-1:0] form_long;
    logic [LONG_W-1:0] long_raw;

    assign long_raw   = {hi_field, lo_field, imm_short};
    assign form_short = {{(DATA_W-IMM_W){imm_short[IMM_W-1]}}, imm_short};
    assign form_mid   = {{(DATA_W-MID_W){lo_field[FIELD_W-1]}}, lo_field, imm_short};

    generate
        if (LONG_W >= DATA_W) begin : g_trunc
            assign form_long = long_raw[DATA_W-1:0];
        end else begin : g_ext
            assign form_long = {{(DATA_W-LONG_W){long_raw[LONG_W-1]}}, long_raw};
        end
    endgenerate

    always_comb begin
        if (delay_slot) begin
            imm_full = form_short;
        end else begin
            unique case (state)
                PFX_NONE: imm_full = form_short;
                PFX_ONE:  imm_full = form_mid;
                PFX_TWO:  imm_full = form_long;
                default:  imm_full = form_short;
            endcase
        end
    end
endmodule

// File: rtl/inm_regfile.sv
`timescale 1ns/1ps
module inm_regfile #(
    parameter int NREG   = 16,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [NREG];

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem[g] <= '0;
                end else if (wr_en && wr_addr == AW'(g)) begin
                    mem[g] <= wr_data;
                end
            end
        end
    endgenerate

    assign rd_data = mem[rd_addr];

    // R9
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/imm_not_unit.sv
`timescale 1ns/1ps
module imm_not_unit
    import inm_pkg::*;
#(
    parameter int NREG    = 16,
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 13,
    parameter int IMM_W   = 6,
    parameter int INSN_W  = 16,
    localparam int AW     = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [INSN_W-1:0] insn_word,
    input  logic              in_delay_slot,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c
);
    pfx_state_e         pfx_state;
    logic [FIELD_W-1:0] hi_field;
    logic [FIELD_W-1:0] lo_field;
    logic               is_pfx;
    logic               is_not;
    logic               not_fire;
    logic [DATA_W-1:0]  imm_full;
    logic [DATA_W-1:0]  result;

    assign is_pfx   = insn_word[INSN_W-1 -: 3] == OPC_PFX;
    assign is_not   = insn_word[INSN_W-1 -: 6] == OPC_NOT;
    assign not_fire = insn_valid && is_not;

    inm_prefix_fsm #(.FIELD_W(FIELD_W)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (insn_valid),
        .is_pfx   (is_pfx),
        .field    (insn_word[FIELD_W-1:0]),
        .state    (pfx_state),
        .hi_field (hi_field),
        .lo_field (lo_field)
    );

    inm_imm_build #(.FIELD_W(FIELD_W), .IMM_W(IMM_W), .DATA_W(DATA_W)) i_imm (
        .state      (pfx_state),
        .hi_field   (hi_field),
        .lo_field   (lo_field),
        .imm_short  (insn_word[AW+IMM_W-1:AW]),
        .delay_slot (in_delay_slot),
        .imm_full   (imm_full)
    );

    assign result = ~imm_full;

    inm_regfile #(.NREG(NREG), .DATA_W(DATA_W)) i_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (not_fire),
        .wr_addr (insn_word[AW-1:0]),
        .wr_data (result),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_n <= 1'b0;
            flag_z <= 1'b0;
            flag_v <= 1'b0;
            flag_c <= 1'b0;
        end else if (not_fire) begin
            flag_n <= result[DATA_W-1];
            flag_z <= (result == '0);
            flag_v <= 1'b0;
        end
    end

    // R8
    flag_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        not_fire |=> (!flag_v && flag_n == rd_data[DATA_W-1] || rd_addr != $past(insn_word[AW-1:0])));

    // R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        not_fire |=> (flag_z == ($past(imm_full) == {DATA_W{1'b1}})));

    // R7
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !not_fire |=> $stable({flag_n, flag_z, flag_v, flag_c}));
endmodule

// File: tb/test_imm_not_unit.sv
`timescale 1ns/100ps
module test_imm_not_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [15:0] insn_word = '0;
    logic        in_delay_slot = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        flag_n, flag_z, flag_v, flag_c;

    int total = 0;
    int fails = 0;
    logic [31:0] m_reg [16];
    logic        m_n, m_z, m_v;
    int          q[$];
    int          last_dest = 0;

    always #2 clk = ~clk;

    imm_not_unit i_imm_not_unit (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
        .in_delay_slot(in_delay_slot), .rd_addr(rd_addr), .rd_data(rd_data),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_reg[i] = '0;
        m_n = 0; m_z = 0; m_v = 0;
        q.delete();
    endtask

    function automatic logic [31:0] model_imm(input logic [15:0] w, input logic ds);
        int v6 = int'(w[9:4]);
        int n = ds ? 0 : q.size();
        int val;
        if (n == 0) begin
            val = (v6 >= 32) ? v6 - 64 : v6;
            return 32'(val);
        end else if (n == 1) begin
            val = q[0] * 64 + v6;
            if (val >= (1 << 18)) val = val - (1 << 19);
            return 32'(val);
        end
        return (32'(q[0]) << 19) | (32'(q[1]) << 6) | 32'(v6);
    endfunction

    task automatic model_step(input logic v, input logic [15:0] w, input logic ds);
        logic [31:0] r;
        if (!v) return;
        if (w[15:13] == 3'b110) begin
            q.push_back(int'(w[12:0]));
            if (q.size() > 2) void'(q.pop_front());
        end else begin
            if (w[15:10] == 6'b011111) begin
                r = ~model_imm(w, ds);
                m_reg[w[3:0]] = r;
                m_n = r[31]; m_z = (r == 0); m_v = 0;
                last_dest = int'(w[3:0]);
            end
            q.delete();
        end
    endtask

    // Called at a negedge; returns at the next negedge.
    task automatic step(input logic v, input logic [15:0] w, input logic ds, input string req);
        insn_valid = v; insn_word = w; in_delay_slot = ds;
        @(posedge clk);
        model_step(v, w, ds);
        #1;
        insn_valid = 0; in_delay_slot = 0;
        chk({req, " R9 N"}, 32'(flag_n), 32'(m_n));
        chk({req, " R9 Z"}, 32'(flag_z), 32'(m_z));
        chk({req, " R8 V"}, 32'(flag_v), 32'(m_v));
        chk({req, " R8 C"}, 32'(flag_c), 32'(0));
        rd_addr = 4'(last_dest);
        #0.2;
        chk({req, " R9 reg"}, rd_data, m_reg[last_dest]);
        @(negedge clk);
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 16; i++) begin
            rd_addr = 4'(i);
            #0.1;
            chk(req, rd_data, m_reg[i]);
        end
        @(negedge clk);
    endtask

    function automatic logic [15:0] w_not(input int rd, input int imm);
        return {6'b011111, 6'(imm), 4'(rd)};
    endfunction
    function automatic logic [15:0] w_pfx(input int f);
        return {3'b110, 13'(f)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        sweep("R11 reset regs");
        chk("R11 reset flags", {28'd0, flag_n, flag_z, flag_v, flag_c}, 32'd0);

        step(1, w_not(0, 'h1f), 0, "R2");
        chk("R2 example", m_reg[0], 32'hffffffe0);
        step(1, w_pfx('h7ff), 0, "R3");
        step(1, w_not(1, 'h3f), 0, "R3");
        chk("R3 example", m_reg[1], 32'hfffe0000);
        step(1, w_pfx('h1abc), 0, "R4");
        step(1, w_pfx('h0123), 0, "R4");
        step(1, w_not(2, 'h15), 0, "R4");
        step(1, w_pfx('h0001), 0, "R5");
        step(1, w_pfx('h1fff), 0, "R5");
        step(1, w_pfx('h0a5a), 0, "R5");
        step(1, w_not(3, 'h2a), 0, "R5");
        step(1, w_pfx('h1234), 0, "R6");
        step(1, w_pfx('h0567), 0, "R6");
        step(1, w_not(4, 'h05), 1, "R6");
        step(1, w_not(5, 'h05), 0, "R6 cleared");
        step(1, w_pfx('h0fff), 0, "R7");
        step(1, 16'h0000, 0, "R7 foreign");
        step(1, w_not(6, 'h10), 0, "R7");
        step(1, 16'h8123, 0, "R7 foreign");
        sweep("R7 no write");
        step(1, w_pfx('h0333), 0, "R10");
        step(0, w_pfx('h1111), 0, "R10");
        step(0, w_not(7, 0), 0, "R10");
        step(1, w_not(7, 'h01), 0, "R10");
        sweep("R10 regs");
        step(1, w_not(8, 'h3f), 0, "R8 zero");
        chk("R8 Z set", 32'(flag_z), 32'd1);
        step(1, w_not(9, 'h00), 0, "R8 neg");
        step(1, w_pfx('h0444), 0, "R1");
        step(1, w_pfx('h1888), 0, "R1");
        step(1, w_not(10, 'h3f), 0, "R1");
        // R11: reset clears pending prefixes
        step(1, w_pfx('h1234), 0, "R11");
        rst_n = 0; model_reset();
        @(negedge clk); rst_n = 1; @(negedge clk);
        sweep("R11 mid reset");
        step(1, w_not(2, 'h00), 0, "R11 pending cleared");
        chk("R11 value", m_reg[2], 32'hffffffff);

        for (int k = 0; k < 500; k++) begin
            int sel = $urandom_range(0, 9);
            logic [15:0] w = 16'($urandom);
            logic v = 1;
            if (sel < 4) w[15:13] = 3'b110;
            else if (sel < 8) w[15:10] = 6'b011111;
            else if (sel == 8) v = 0;
            step(v, w, ($urandom_range(0, 5) == 0), "R1 mix");
        end
        sweep("R4 final regs");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule